// File: doc/BRIEF.md
# Small Four-Function ALU

This block is a purely combinational arithmetic-logic unit for two narrow unsigned operands (3 bits by default). A 2-bit operation code selects one of four separate sub-units: an adder, a subtractor, a bitwise AND unit and a bitwise OR unit. The selected unit's value appears on the result output. A single flag reports a carry out of the adder or a borrow out of the subtractor.

The two arithmetic units work on operands widened by one zero bit. The extra top bit of that widened sum or difference is the unit's flag. The flag leaves the block only while an arithmetic code is selected, and it reads 0 for both logic codes. There is no clock and no stored state: the outputs follow the present inputs alone.

Top module: `small_alu`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (a_in + b_in) modulo 2^W.
- R2: With op_sel = 2'b01 (subtract), result equals (a_in - b_in) modulo 2^W.
- R3: With op_sel = 2'b10 (and), result equals the bitwise AND of a_in and b_in.
- R4: With op_sel = 2'b11 (or), result equals the bitwise OR of a_in and b_in.
- R5: With the add code, carry_flag equals bit W of the (W+1)-bit sum of the zero-extended operands. It is 1 exactly when a_in + b_in > 2^W - 1.
- R6: With the subtract code, carry_flag equals bit W of the (W+1)-bit difference of the zero-extended operands. It is 1 exactly when b_in > a_in, which is a borrow.
- R7: With either logic code (op_sel[1] = 1), carry_flag is 0, including for operands whose sum or difference would carry or borrow.
- R8: The outputs depend only on the present inputs. Applying an input set again after any other inputs gives the same outputs as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W (3) | First unsigned operand |
| b_in | input | W (3) | Second unsigned operand |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 and, 11 or |
| result | output | W (3) | Value of the selected sub-unit |
| carry_flag | output | 1 | Carry (add) or borrow (subtract); 0 for logic codes |

## Verification
Two things can happen in the same evaluation: an arithmetic sub-unit raises its carry or borrow, and a logic operation is selected. The flag must then stay low, even though the arithmetic units keep computing in parallel. The bench provokes this by holding operands that overflow, for example 7 and 1 or 2 and 5, while it steps op_sel through all four codes. It judges each code against flag and result values computed independently. An exhaustive sweep and seeded random vectors cover every other pairing of an overflowing unit with a logic code.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  // Arithmetic codes are those with the top code bit clear.
  function automatic logic op_is_arith(input logic [1:0] op);
    return ~op[1];
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W        = 3,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] val,
  output logic         top_bit
);
  localparam int WX = W + 1;

  function automatic logic [WX-1:0] wide_add(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  function automatic logic [WX-1:0] wide_sub(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} - {1'b0, q};
  endfunction

  logic [WX-1:0] wide;

  generate
    if (SUBTRACT) begin : g_sub
      assign wide = wide_sub(x, y);
    end else begin : g_add
      assign wide = wide_add(x, y);
    end
  endgenerate

  assign val     = wide[W-1:0];
  assign top_bit = wide[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W      = 3,
  parameter bit USE_OR = 1'b0
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] val
);
  generate
    if (USE_OR) begin : g_or
      assign val = x | y;
    end else begin : g_and
      assign val = x & y;
    end
  endgenerate
endmodule

// File: rtl/small_alu.sv
module small_alu #(
  parameter int W = 3
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_flag
);
  import alu_pkg::*;

  // Named sub-unit outputs, visible to the bound checker.
  logic [W-1:0] add_val, sub_val, and_val, or_val;
  logic         add_cy, sub_brw;

  alu_arith #(.W(W), .SUBTRACT(1'b0)) u_add (
    .x(a_in), .y(b_in), .val(add_val), .top_bit(add_cy));

  alu_arith #(.W(W), .SUBTRACT(1'b1)) u_sub (
    .x(a_in), .y(b_in), .val(sub_val), .top_bit(sub_brw));

  alu_bitwise #(.W(W), .USE_OR(1'b0)) u_and (
    .x(a_in), .y(b_in), .val(and_val));

  alu_bitwise #(.W(W), .USE_OR(1'b1)) u_or (
    .x(a_in), .y(b_in), .val(or_val));

  // Output selection; every code drives both outputs.
  always_comb begin
    case (alu_op_e'(op_sel))
      OP_ADD:  begin result = add_val; carry_flag = add_cy;  end
      OP_SUB:  begin result = sub_val; carry_flag = sub_brw; end
      OP_AND:  begin result = and_val; carry_flag = 1'b0;    end
      default: begin result = or_val;  carry_flag = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/small_alu_checks.sv
module small_alu_checks #(
  parameter int W = 3
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [1:0]   op_sel,
  input logic [W-1:0] result,
  input logic         carry_flag,
  input logic [W-1:0] add_val,
  input logic [W-1:0] sub_val,
  input logic         add_cy,
  input logic         sub_brw
);
  logic known;
  assign known = !$isunknown({a_in, b_in, op_sel, result, carry_flag, add_cy, sub_brw});

  always_comb begin
    if (known) begin
      assert_add_result_R1: assert (op_sel != 2'b00 || result == add_val)
        else $error("add result not routed");
      assert_sub_result_R2: assert (op_sel != 2'b01 || result == sub_val)
        else $error("sub result not routed");
      assert_logic_R3: assert (op_sel != 2'b10 || result == (a_in & b_in))
        else $error("and result wrong");
      assert_logic_R4: assert (op_sel != 2'b11 || result == (a_in | b_in))
        else $error("or result wrong");
      assert_add_carry_R5: assert (op_sel != 2'b00 || carry_flag == add_cy)
        else $error("add carry not routed");
      assert_borrow_R6: assert (sub_brw == (b_in > a_in))
        else $error("borrow does not match operand order");
      assert_no_overflow_R7: assert (!(op_sel[1] && carry_flag))
        else $error("flag raised for logic code");
    end
  end
endmodule

bind small_alu small_alu_checks #(.W(W)) u_checks (
  .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
  .result(result), .carry_flag(carry_flag),
  .add_val(add_val), .sub_val(sub_val),
  .add_cy(add_cy), .sub_brw(sub_brw));

// File: tb/tb_small_alu.sv
module tb_small_alu;
  localparam int W = 3;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [W-1:0] a, b, res;
  logic [1:0]   op;
  logic         flg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  small_alu #(.W(W)) dut (.a_in(a), .b_in(b), .op_sel(op), .result(res), .carry_flag(flg));

  function automatic int exp_res(int x, int y, int o);
    case (o)
      0: return (x + y) % M;
      1: return (x + M - y) % M;
      2: return x & y;
      default: return x | y;
    endcase
  endfunction

  function automatic int exp_flg(int x, int y, int o);
    if (o == 0) return (x + y >= M) ? 1 : 0;
    if (o == 1) return (y > x) ? 1 : 0;
    return 0;
  endfunction

  function automatic string req_res(int o);
    case (o) 0: return "R1"; 1: return "R2"; 2: return "R3"; default: return "R4"; endcase
  endfunction

  function automatic string req_flg(int o);
    case (o) 0: return "R5"; 1: return "R6"; default: return "R7"; endcase
  endfunction

  task automatic apply(int x, int y, int o);
    @(negedge clk);
    a = W'(x); b = W'(y); op = 2'(o);
    #1;
  endtask

  task automatic judge(int x, int y, int o);
    checks++;
    if (int'(res) != exp_res(x, y, o)) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d op=%0d result=%0d expected=%0d",
               req_res(o), x, y, o, res, exp_res(x, y, o));
    end
    checks++;
    if (int'(flg) != exp_flg(x, y, o)) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d op=%0d flag=%0d expected=%0d",
               req_flg(o), x, y, o, flg, exp_flg(x, y, o));
    end
  endtask

  task automatic run(int x, int y, int o);
    apply(x, y, o);
    judge(x, y, o);
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    void'($urandom(32'd20240611));
    // Idle state: zero inputs give zero outputs (R1, R5).
    run(0, 0, 0);
    // Directed corners.
    run(7, 1, 0);  // R1 R5 wrap with carry
    run(2, 5, 1);  // R2 R6 borrow
    run(7, 7, 3);  // R4 R7
    run(5, 5, 1);  // R6 equal operands, no borrow
    run(7, 0, 0);  // R5 no carry at max
    // Overflowing operands held while the code steps through logic ops (R7).
    for (int o = 0; o < 4; o++) run(7, 1, o);
    for (int o = 0; o < 4; o++) run(2, 5, o);
    for (int o = 0; o < 4; o++) run(7, 7, o);
    // Exhaustive sweep.
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < M; x++)
        for (int y = 0; y < M; y++)
          run(x, y, o);
    // Seeded random vectors.
    for (int i = 0; i < 400; i++)
      run(int'($urandom_range(M - 1)), int'($urandom_range(M - 1)), int'($urandom_range(3)));
    // R8: revisit an input set after unrelated traffic; outputs must match.
    begin
      logic [W-1:0] r0;
      logic f0;
      apply(3, 6, 1);
      r0 = res; f0 = flg;
      run(7, 7, 0);
      run(0, 4, 2);
      apply(3, 6, 1);
      checks++;
      if (res !== r0 || flg !== f0) begin
        errors++;
        $display("FAIL R8 revisit result=%0d flag=%0d expected=%0d flag %0d", res, flg, r0, f0);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule